// File: doc/BRIEF.md
# Masked Content-Addressable Lookup Table

This block is a small associative table of 64-bit entries. Each entry is split by a programmable boundary. The low bits form a match field that is compared against a search key. The remaining high bits are the output field that a hit returns. A global mask register makes selected key bits don't-care. An optional dual-lookup mode reports a coarse path match alongside the full match in the same search.

Two independent ports drive the block. The control port loads the mask, sets the field boundary and the dual-lookup mode, and pushes new entries into a 14-deep insertion queue. Queued entries move into the lowest free table slot, one per cycle, whenever the table is not in use by a search. The match port starts a two-cycle search. It returns hit, multi-hit, the winning index and the winner's output field, and raises a completion strobe when the result is ready.

Top module: `cam_lookup`

## Requirements
- R1: After reset, ctl_ready is 1, irq, m_busy and m_done are 0, the mask is all zero, the match field covers all 64 bits, dual-lookup mode is off and every table slot is empty.
- R2: The insertion queue holds 14 entries. ctl_ready is 1 exactly while fewer than 14 entries are queued, and an insert offered while ctl_ready is 0 is discarded.
- R3: A queued entry is written into the lowest-numbered empty slot, at most one per cycle. This happens only in a cycle where m_busy is 0 and m_req is 0, so a new search takes priority over draining.
- R4: m_req is accepted when m_busy is 0. m_busy is 1 in the next cycle and m_done pulses for one cycle after that with the result. An m_req seen while m_busy is 1 is ignored.
- R5: An entry hits when its slot is valid and it equals the key on every bit that is inside the match field and not masked.
- R6: ctl_op 1 loads ctl_data into the mask register, and a mask bit of 1 removes that bit position from every comparison.
- R7: ctl_op 2 sets the match field to the lowest ctl_data[6:0] bits (values of 64 or more select all 64 bits). On a hit, m_out is the winning entry with its match-field bits forced to zero. On a miss, m_out is zero.
- R8: When several entries hit, m_index reports the lowest hitting slot and m_multi is 1. m_index is 0 on a miss.
- R9: ctl_data[7] written with ctl_op 2 enables dual-lookup mode. In this mode m_path_hit reports a hit computed only on the match-field bits at positions 16 and above. Outside this mode m_path_hit is 0.
- R10: irq pulses for one cycle after an insert (ctl_op 0) is offered while the queue holds 14 entries and every table slot is valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_valid | input | 1 | Control operation present |
| ctl_op | input | 2 | 0 insert, 1 load mask, 2 configure, 3 no operation |
| ctl_data | input | 64 | Entry, mask, or configuration word |
| ctl_ready | output | 1 | Queue can accept an insert |
| irq | output | 1 | Insert refused with queue and table both full |
| m_req | input | 1 | Start a search |
| m_key | input | 64 | Search key |
| m_busy | output | 1 | Search in progress |
| m_done | output | 1 | Result valid strobe |
| m_hit | output | 1 | Full match-field hit |
| m_multi | output | 1 | More than one entry hit |
| m_path_hit | output | 1 | Path-only hit in dual-lookup mode |
| m_index | output | 3 | Winning slot |
| m_out | output | 64 | Winning entry with match-field bits cleared |

## Verification
The search is run with three stored entries, two of which share a key. This separates a single hit from a multi-hit and checks that the lowest index wins. Keys that differ in one bit, with and without that bit masked, show that the mask really removes positions from the compare, while a mask confined to the output field shows it does not. Narrowing the field boundary changes both which entries collide and which bits m_out clears. A full-width boundary turns the high bits into compared bits. Dual-lookup keys that agree only on the path bits separate m_path_hit from m_hit. A search issued right after an insert shows that draining yields to the search.

// File: rtl/cam_pkg.sv
`timescale 1ns/1ps
package cam_pkg;
  typedef enum logic [1:0] {
    OP_INSERT = 2'd0,
    OP_MASK   = 2'd1,
    OP_CONFIG = 2'd2,
    OP_NONE   = 2'd3
  } ctl_op_e;
endpackage

// File: rtl/cam_fifo.sv
`timescale 1ns/1ps
module cam_fifo #(
  parameter int W     = 64,
  parameter int DEPTH = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (push) wr_d = (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    if (pop)  rd_d = (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    if (push && !pop) cnt_d = cnt_q + 1'b1;
    else if (pop && !push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= din;
  end

  assign dout  = mem[rd_q];
  assign full  = (cnt_q == CNT_W'(DEPTH));
  assign empty = (cnt_q == '0);

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n) push |-> !full);
  // R3
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty);
endmodule

// File: rtl/cam_prio.sv
`timescale 1ns/1ps
module cam_prio #(
  parameter int N = 8
) (
  input  logic [N-1:0]         req,
  output logic                 any,
  output logic                 multi,
  output logic [$clog2(N)-1:0] idx
);
  localparam int IDX_W = $clog2(N);

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end

  assign any   = |req;
  assign multi = |(req & (req - 1'b1));
endmodule

// File: rtl/cam_store.sv
`timescale 1ns/1ps
module cam_store #(
  parameter int W = 64,
  parameter int N = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [$clog2(N)-1:0] wr_idx,
  input  logic [W-1:0]         wr_data,
  input  logic [W-1:0]         key,
  input  logic [W-1:0]         care,
  input  logic [W-1:0]         path_care,
  input  logic [$clog2(N)-1:0] rd_idx,
  output logic [W-1:0]         rd_data,
  output logic [N-1:0]         valid,
  output logic [N-1:0]         hit_vec,
  output logic [N-1:0]         path_vec
);
  logic [W-1:0] ent [N];
  logic [N-1:0] valid_d;

  always_comb begin
    valid_d = valid;
    if (wr_en) valid_d[wr_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid <= '0;
    else        valid <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) ent[wr_idx] <= wr_data;
  end

  for (genvar g = 0; g < N; g++) begin : g_cmp
    logic [W-1:0] diff;
    assign diff        = ent[g] ^ key;
    assign hit_vec[g]  = valid[g] && ((diff & care) == '0);
    assign path_vec[g] = valid[g] && ((diff & path_care) == '0);
  end

  assign rd_data = ent[rd_idx];
endmodule

// File: rtl/cam_lookup.sv
`timescale 1ns/1ps
module cam_lookup #(
  parameter int W      = 64,
  parameter int N      = 8,
  parameter int QDEPTH = 14,
  parameter int CIRC_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ctl_valid,
  input  logic [1:0]           ctl_op,
  input  logic [W-1:0]         ctl_data,
  output logic                 ctl_ready,
  output logic                 irq,
  input  logic                 m_req,
  input  logic [W-1:0]         m_key,
  output logic                 m_busy,
  output logic                 m_done,
  output logic                 m_hit,
  output logic                 m_multi,
  output logic                 m_path_hit,
  output logic [$clog2(N)-1:0] m_index,
  output logic [W-1:0]         m_out
);
  import cam_pkg::*;
  localparam int IDX_W   = $clog2(N);
  localparam int SPLIT_W = $clog2(W + 1);

  ctl_op_e op;
  assign op = ctl_op_e'(ctl_op);

  // control registers
  logic [W-1:0]       mask_q, mask_d;
  logic [SPLIT_W-1:0] split_q, split_d;
  logic               atm_q, atm_d;
  // search registers
  logic [W-1:0]       key_q, key_d, out_q, out_d;
  logic               busy_q, busy_d, done_q, done_d, irq_q, irq_d;
  logic               hit_q, hit_d, multi_q, multi_d, path_q, path_d;
  logic [IDX_W-1:0]   idx_q, idx_d;

  logic [W-1:0] field_mask, care, path_care, fifo_dout, rd_data;
  logic [N-1:0] valid, hit_vec, path_vec;
  logic         push, pop, q_full, q_empty, start;
  logic         free_any, free_multi, win_any, win_multi, path_any, path_multi;
  logic [IDX_W-1:0] free_idx, win_idx, path_idx;

  always_comb begin
    for (int i = 0; i < W; i++) begin
      field_mask[i] = (SPLIT_W'(i) < split_q);
      path_care[i]  = care[i] && (i >= CIRC_W);
    end
  end
  assign care = field_mask & ~mask_q;

  assign start = m_req && !busy_q;
  assign push  = ctl_valid && (op == OP_INSERT) && !q_full;
  assign pop   = !q_empty && free_any && !busy_q && !m_req;

  cam_fifo #(.W(W), .DEPTH(QDEPTH)) u_queue (
    .clk(clk), .rst_n(rst_n), .push(push), .din(ctl_data), .pop(pop),
    .dout(fifo_dout), .full(q_full), .empty(q_empty)
  );

  cam_store #(.W(W), .N(N)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(pop), .wr_idx(free_idx), .wr_data(fifo_dout),
    .key(key_q), .care(care), .path_care(path_care), .rd_idx(win_idx),
    .rd_data(rd_data), .valid(valid), .hit_vec(hit_vec), .path_vec(path_vec)
  );

  cam_prio #(.N(N)) u_free (.req(~valid), .any(free_any), .multi(free_multi), .idx(free_idx));
  cam_prio #(.N(N)) u_win  (.req(hit_vec), .any(win_any), .multi(win_multi), .idx(win_idx));
  cam_prio #(.N(N)) u_path (.req(path_vec), .any(path_any), .multi(path_multi), .idx(path_idx));

  always_comb begin
    mask_d  = mask_q;
    split_d = split_q;
    atm_d   = atm_q;
    if (ctl_valid && op == OP_MASK) mask_d = ctl_data;
    if (ctl_valid && op == OP_CONFIG) begin
      split_d = ctl_data[SPLIT_W-1:0];
      atm_d   = ctl_data[SPLIT_W];
    end
    irq_d   = ctl_valid && (op == OP_INSERT) && q_full && !free_any;
    key_d   = start ? m_key : key_q;
    busy_d  = start;
    done_d  = busy_q;
    hit_d   = hit_q;
    multi_d = multi_q;
    path_d  = path_q;
    idx_d   = idx_q;
    out_d   = out_q;
    if (busy_q) begin
      hit_d   = win_any;
      multi_d = win_multi;
      path_d  = atm_q && path_any;
      idx_d   = win_any ? win_idx : '0;
      out_d   = win_any ? (rd_data & ~field_mask) : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      split_q <= SPLIT_W'(W);
      atm_q   <= 1'b0;
      key_q   <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      irq_q   <= 1'b0;
      hit_q   <= 1'b0;
      multi_q <= 1'b0;
      path_q  <= 1'b0;
      idx_q   <= '0;
      out_q   <= '0;
    end else begin
      mask_q  <= mask_d;
      split_q <= split_d;
      atm_q   <= atm_d;
      key_q   <= key_d;
      busy_q  <= busy_d;
      done_q  <= done_d;
      irq_q   <= irq_d;
      hit_q   <= hit_d;
      multi_q <= multi_d;
      path_q  <= path_d;
      idx_q   <= idx_d;
      out_q   <= out_d;
    end
  end

  assign ctl_ready  = !q_full;
  assign irq        = irq_q;
  assign m_busy     = busy_q;
  assign m_done     = done_q;
  assign m_hit      = hit_q;
  assign m_multi    = multi_q;
  assign m_path_hit = path_q;
  assign m_index    = idx_q;
  assign m_out      = out_q;

  // R4
  req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && !m_busy) |=> (m_busy && !m_done));
  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_busy |=> (m_done && !m_busy));
  // R8
  multi_hit_chk: assert property (@(posedge clk) disable iff (!rst_n) m_multi |-> m_hit);
  // R3
  tbl_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_busy |=> $stable(valid));
  // R10
  irq_full_chk: assert property (@(posedge clk) disable iff (!rst_n) irq |-> !ctl_ready);
  // R3
  one_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(valid ^ $past(valid)) <= 1);
endmodule

// File: tb/sim_cam_lookup.sv
`timescale 1ns/1ps
module sim_cam_lookup;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ctl_valid, ctl_ready, irq;
  logic [1:0]  ctl_op;
  logic [63:0] ctl_data, m_key, m_out;
  logic        m_req, m_busy, m_done, m_hit, m_multi, m_path_hit;
  logic [2:0]  m_index;
  int          n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  cam_lookup u0 (
    .clk(clk), .rst_n(rst_n), .ctl_valid(ctl_valid), .ctl_op(ctl_op), .ctl_data(ctl_data),
    .ctl_ready(ctl_ready), .irq(irq), .m_req(m_req), .m_key(m_key), .m_busy(m_busy),
    .m_done(m_done), .m_hit(m_hit), .m_multi(m_multi), .m_path_hit(m_path_hit),
    .m_index(m_index), .m_out(m_out)
  );

  localparam int NV = 7;
  localparam logic [63:0] VKEY  [NV] = '{64'hFFFFFFFF_11112222, 64'h0_33334444, 64'h0_55556666,
    64'h0_11112223, 64'h0_11112223, 64'h0_3333444F, 64'h0_33334444};
  localparam logic [63:0] VMASK [NV] = '{64'h0, 64'h0, 64'h0, 64'h0, 64'h1, 64'hF,
    64'hFFFF0000_00000000};
  localparam logic [NV-1:0] VHIT  = 7'b111_0011;
  localparam logic [NV-1:0] VMULT = 7'b001_0001;
  localparam logic [2:0]  VIDX  [NV] = '{3'd0, 3'd1, 3'd0, 3'd0, 3'd0, 3'd1, 3'd1};
  localparam logic [63:0] VOUT  [NV] = '{64'hA0A0A0A0_00000000, 64'hB0B0B0B0_00000000, 64'h0,
    64'h0, 64'hA0A0A0A0_00000000, 64'hB0B0B0B0_00000000, 64'hB0B0B0B0_00000000};

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic ctl(input logic [1:0] op, input logic [63:0] d);
    @(negedge clk);
    ctl_valid = 1'b1; ctl_op = op; ctl_data = d;
    @(posedge clk);
    @(negedge clk);
    ctl_valid = 1'b0; ctl_op = 2'd3;
  endtask

  task automatic search(input logic [63:0] k);
    @(negedge clk);
    m_req = 1'b1; m_key = k;
    @(posedge clk);
    @(negedge clk);
    m_req = 1'b0;
    chk("R4 busy", {63'b0, m_busy}, 64'd1);
    chk("R4 done early", {63'b0, m_done}, 64'd0);
    @(posedge clk);
    @(negedge clk);
    chk("R4 done", {63'b0, m_done}, 64'd1);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    rst_n = 1'b0; ctl_valid = 1'b0; ctl_op = 2'd3; ctl_data = '0; m_req = 1'b0; m_key = '0;
    idle(3);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ready", {63'b0, ctl_ready}, 64'd1);
    chk("R1 irq", {63'b0, irq}, 64'd0);
    chk("R1 busy", {63'b0, m_busy}, 64'd0);
    chk("R1 done", {63'b0, m_done}, 64'd0);
    search(64'h0);
    chk("R1 empty table", {63'b0, m_hit}, 64'd0);

    ctl(2'd2, 64'h20);
    ctl(2'd0, 64'hA0A0A0A0_11112222);
    ctl(2'd0, 64'hB0B0B0B0_33334444);
    ctl(2'd0, 64'hC0C0C0C0_11112222);
    idle(20);

    // R5 R6 R7 R8 vector walk
    for (int v = 0; v < NV; v++) begin
      ctl(2'd1, VMASK[v]);
      search(VKEY[v]);
      chk("R5 hit", {63'b0, m_hit}, {63'b0, VHIT[v]});
      chk("R8 multi", {63'b0, m_multi}, {63'b0, VMULT[v]});
      chk("R8 index", {61'b0, m_index}, {61'b0, VIDX[v]});
      chk("R7 out", m_out, VOUT[v]);
      chk("R9 path off", {63'b0, m_path_hit}, 64'd0);
    end
    ctl(2'd1, 64'h0);

    // R7 narrow field: 16 bits
    ctl(2'd2, 64'h10);
    search(64'h0_00002222);
    chk("R7 narrow hit", {63'b0, m_multi}, 64'd1);
    chk("R7 narrow out", m_out, 64'hA0A0A0A0_11110000);
    // R7 oversize field value selects all 64 bits
    ctl(2'd2, 64'h64);
    search(64'hA0A0A0A0_11112222);
    chk("R7 full hit", {63'b0, m_hit}, 64'd1);
    chk("R7 full single", {63'b0, m_multi}, 64'd0);
    chk("R7 full out", m_out, 64'h0);

    // R9 dual lookup
    ctl(2'd2, 64'hA0);
    search(64'h0_11119999);
    chk("R9 circuit miss", {63'b0, m_hit}, 64'd0);
    chk("R9 path hit", {63'b0, m_path_hit}, 64'd1);
    search(64'h0_33334444);
    chk("R9 both hit", {63'b0, m_hit & m_path_hit}, 64'd1);
    chk("R9 index", {61'b0, m_index}, 64'd1);
    ctl(2'd2, 64'h20);

    // R4 request during busy is ignored
    @(negedge clk); m_req = 1'b1; m_key = 64'h0_33334444;
    @(posedge clk);
    @(negedge clk); m_key = 64'h0_55556666;
    @(posedge clk);
    @(negedge clk); m_req = 1'b0;
    chk("R4 first result", {63'b0, m_hit}, 64'd1);
    @(posedge clk);
    @(negedge clk);
    chk("R4 second ignored", {63'b0, m_done | m_busy}, 64'd0);

    // R3 search beats drain
    @(negedge clk);
    ctl_valid = 1'b1; ctl_op = 2'd0; ctl_data = 64'hD0D0D0D0_77778888;
    @(posedge clk);
    @(negedge clk);
    ctl_valid = 1'b0; ctl_op = 2'd3; m_req = 1'b1; m_key = 64'h0_77778888;
    @(posedge clk);
    @(negedge clk); m_req = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R3 drain deferred", {63'b0, m_hit}, 64'd0);
    idle(5);
    search(64'h0_77778888);
    chk("R3 lowest free slot", {61'b0, m_index}, 64'd3);
    chk("R3 out", m_out, 64'hD0D0D0D0_00000000);

    // fill table, then queue
    for (int k = 0; k < 4; k++) ctl(2'd0, 64'h1000 + 64'(k));
    idle(10);
    for (int k = 0; k < 14; k++) begin
      ctl(2'd0, 64'h2000 + 64'(k));
      if (k == 12) chk("R2 ready at 13", {63'b0, ctl_ready}, 64'd1);
    end
    chk("R2 ready at 14", {63'b0, ctl_ready}, 64'd0);
    chk("R10 no irq yet", {63'b0, irq}, 64'd0);
    ctl(2'd0, 64'h3000);
    chk("R10 irq", {63'b0, irq}, 64'd1);
    @(posedge clk);
    @(negedge clk);
    chk("R10 irq pulse", {63'b0, irq}, 64'd0);
    chk("R2 still full", {63'b0, ctl_ready}, 64'd0);
    summary();
  end
endmodule